// File: doc/BRIEF.md
# Iterative Carry-Less Multiplier

This block forms the carry-less product of two 64-bit factors: polynomial multiplication over GF(2), where partial products are combined with XOR instead of addition. The result is 128 bits wide. It sits behind a packed carry-less multiply operation in an execution pipeline. The caller presents two 128-bit register operands and an 8-bit control byte, and raises a one-cycle start strobe. Two bits of the control byte choose which 64-bit half of each operand is used as a factor.

The product is built serially. The chosen multiplier half is examined one bit per clock, least significant bit first. While a 1 is seen, the running 128-bit accumulator absorbs the shifted multiplicand. The multiplicand moves left by one position per clock across its full 128 bits, and the multiplier moves right by one. The loop stops as soon as no set bit remains in the multiplier, so short multipliers finish early. A one-cycle done strobe marks the new result.

A feature-enable input stands in for the condition that the operation is available. If it is low when a start arrives, the block reports an illegal operation with the done strobe and leaves the result untouched.

Top module: `clmul_seq_unit`

## Requirements
- R1: Control bit 0 picks the first factor: 1 selects bits 127:64 of `dst_i`, 0 selects bits 63:0.
- R2: Control bit 4 picks the second factor (the multiplier): 1 selects bits 127:64 of `src_i`, 0 selects bits 63:0.
- R3: `result_o` holds the full carry-less product of the two factors. Bits 63:0 hold the low product word and bits 127:64 hold the high word, and all 128 bits are replaced on completion.
- R4: Control bits 1, 2, 3, 5, 6 and 7 have no effect on the result or on the timing.
- R5: Count the accepting clock edge as edge 1. If the multiplier is zero, `done_o` is high after edge 1 and the result is zero. Otherwise `done_o` is high after edge m+2, where m is the index of the multiplier's highest set bit. The worst case is 64 iteration edges.
- R6: `done_o` is high for exactly one cycle per accepted operation. `busy_o` is high on every cycle between acceptance and completion, and is low while `done_o` is high.
- R7: A start that arrives while `busy_o` is high is dropped. It does not change the running product and does not produce a later done strobe.
- R8: A start with `feat_en_i` low raises `illegal_o` and `done_o` together one edge later. It does not set `busy_o` and leaves `result_o` unchanged.
- R9: Synchronous active-high `rst` clears `busy_o`, `done_o`, `illegal_o`, the accumulator and `result_o`, and abandons any operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | One-cycle request strobe |
| feat_en_i | input | 1 | Operation-available flag |
| dst_i | input | 2*HALF_W | First operand (factor source A) |
| src_i | input | 2*HALF_W | Second operand (factor source B) |
| imm_i | input | 8 | Control byte; bits 0 and 4 select halves |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion strobe |
| illegal_o | output | 1 | Operation refused, valid with done |
| result_o | output | 2*HALF_W | Carry-less product, low word in the lower half |

## Verification
The bench builds the block with the default HALF_W of 64, so factors span the full 64 bits. A multiplier whose top bit is set drives the loop to the 64-step worst case. A multiplicand with bit 63 set moves bits across the word boundary into the high product word. The same width lets a second start arrive deep inside a long run, and a reset land partway through the iteration.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int IMM_W     = 8;
  localparam int IMM_A_POS = 0;
  localparam int IMM_B_POS = 4;
  localparam logic [IMM_W-1:0] IMM_SEL_MASK =
    IMM_W'((1 << IMM_A_POS) | (1 << IMM_B_POS));

  typedef struct packed {
    logic a_hi;
    logic b_hi;
  } half_sel_t;
endpackage

// File: rtl/clmul_opsel.sv
module clmul_opsel
  import clmul_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] dst_i,
  input  logic [2*HALF_W-1:0] src_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic [HALF_W-1:0]   a_half_o,
  output logic [HALF_W-1:0]   b_half_o,
  output logic                b_zero_o
);
  localparam int OPND_W = 2 * HALF_W;

  function automatic logic [HALF_W-1:0] pick_half(input logic [OPND_W-1:0] v,
                                                  input logic hi);
    return hi ? v[OPND_W-1:HALF_W] : v[HALF_W-1:0];
  endfunction

  half_sel_t sel;
  logic      unused_imm_bits;

  assign sel.a_hi = imm_i[IMM_A_POS];
  assign sel.b_hi = imm_i[IMM_B_POS];
  assign unused_imm_bits = ^(imm_i & ~IMM_SEL_MASK);

  assign a_half_o = pick_half(dst_i, sel.a_hi);
  assign b_half_o = pick_half(src_i, sel.b_hi);
  assign b_zero_o = (b_half_o == '0);
endmodule

// File: rtl/clmul_ctrl.sv
module clmul_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic feat_en_i,
  input  logic b_zero_i,
  input  logic last_i,
  output logic busy_o,
  output logic done_o,
  output logic illegal_o,
  output logic accept_o,
  output logic reject_o,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic zero_fin_o
);
  logic go;

  assign accept_o   = start_i && !busy_o;
  assign reject_o   = accept_o && !feat_en_i;
  assign go         = accept_o && feat_en_i;
  assign zero_fin_o = go && b_zero_i;
  assign load_o     = go && !b_zero_i;
  assign step_o     = busy_o;
  assign finish_o   = busy_o && last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o    <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      if (load_o)        busy_o <= 1'b1;
      else if (finish_o) busy_o <= 1'b0;
      done_o    <= reject_o || zero_fin_o || finish_o;
      illegal_o <= reject_o;
    end
  end
endmodule

// File: rtl/clmul_datapath.sv
module clmul_datapath #(
  parameter int HALF_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                step_i,
  input  logic                finish_i,
  input  logic                zero_fin_i,
  input  logic [HALF_W-1:0]   a_half_i,
  input  logic [HALF_W-1:0]   b_half_i,
  output logic                last_o,
  output logic [2*HALF_W-1:0] result_o
);
  localparam int PROD_W = 2 * HALF_W;

  function automatic logic [PROD_W-1:0] fold_in(input logic [PROD_W-1:0] acc,
                                                input logic [PROD_W-1:0] mcand,
                                                input logic              take);
    return take ? (acc ^ mcand) : acc;
  endfunction

  logic [PROD_W-1:0] acc_q;
  logic [PROD_W-1:0] mcand_q;
  logic [HALF_W-1:0] mplier_q;
  logic [PROD_W-1:0] acc_next;

  assign acc_next = fold_in(acc_q, mcand_q, mplier_q[0]);
  assign last_o   = (mplier_q[HALF_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      result_o <= '0;
    end else begin
      if (load_i) begin
        acc_q    <= '0;
        mcand_q  <= {{HALF_W{1'b0}}, a_half_i};
        mplier_q <= b_half_i;
      end else if (step_i) begin
        acc_q    <= acc_next;
        mcand_q  <= {mcand_q[PROD_W-2:0], 1'b0};
        mplier_q <= {1'b0, mplier_q[HALF_W-1:1]};
      end
      if (zero_fin_i)    result_o <= '0;
      else if (finish_i) result_o <= acc_next;
    end
  end
endmodule

// File: rtl/clmul_seq_unit.sv
module clmul_seq_unit
  import clmul_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic                feat_en_i,
  input  logic [2*HALF_W-1:0] dst_i,
  input  logic [2*HALF_W-1:0] src_i,
  input  logic [IMM_W-1:0]    imm_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                illegal_o,
  output logic [2*HALF_W-1:0] result_o
);
  logic [HALF_W-1:0] a_half_w;
  logic [HALF_W-1:0] b_half_w;
  logic              b_zero_w;
  logic              last_w;
  logic              accept_w;
  logic              reject_w;
  logic              load_w;
  logic              step_w;
  logic              finish_w;
  logic              zero_fin_w;

  clmul_opsel #(.HALF_W(HALF_W)) u_opsel (
    .dst_i    (dst_i),
    .src_i    (src_i),
    .imm_i    (imm_i),
    .a_half_o (a_half_w),
    .b_half_o (b_half_w),
    .b_zero_o (b_zero_w)
  );

  clmul_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .feat_en_i  (feat_en_i),
    .b_zero_i   (b_zero_w),
    .last_i     (last_w),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .accept_o   (accept_w),
    .reject_o   (reject_w),
    .load_o     (load_w),
    .step_o     (step_w),
    .finish_o   (finish_w),
    .zero_fin_o (zero_fin_w)
  );

  clmul_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_w),
    .step_i     (step_w),
    .finish_i   (finish_w),
    .zero_fin_i (zero_fin_w),
    .a_half_i   (a_half_w),
    .b_half_i   (b_half_w),
    .last_o     (last_w),
    .result_o   (result_o)
  );
endmodule

// File: rtl/clmul_seq_unit_chk.sv
module clmul_seq_unit_chk #(
  parameter int HALF_W = 64
) (
  input logic                clk,
  input logic                rst,
  input logic                start_i,
  input logic                feat_en_i,
  input logic                busy_o,
  input logic                done_o,
  input logic                illegal_o,
  input logic [2*HALF_W-1:0] result_o,
  input logic                accept_w,
  input logic                reject_w,
  input logic                zero_fin_w,
  input logic                finish_w,
  input logic                b_zero_w
);
  localparam int CNT_W = $clog2(HALF_W + 1);

  logic [CNT_W-1:0] run_cnt;
  logic             rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || !busy_o) run_cnt <= '0;
    else                run_cnt <= run_cnt + 1'b1;
  end

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (!busy_o && !done_o && !illegal_o && result_o == '0));

  p_latency_bound_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_cnt < CNT_W'(HALF_W)));

  p_zero_mult_r5: assert property (@(posedge clk) disable iff (rst)
    (accept_w && feat_en_i && b_zero_w) |=> (done_o && !busy_o && result_o == '0));

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_finish_done_r6: assert property (@(posedge clk) disable iff (rst)
    finish_w |=> (done_o && !busy_o && !illegal_o));

  p_start_dropped_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !finish_w) |=> (busy_o && !done_o));

  p_illegal_done_r8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (done_o && !busy_o));

  p_illegal_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    reject_w |=> (illegal_o && $stable(result_o)));

  p_no_stray_zero_r5: assert property (@(posedge clk) disable iff (rst)
    zero_fin_w |-> !reject_w);
endmodule

bind clmul_seq_unit clmul_seq_unit_chk #(.HALF_W(HALF_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .feat_en_i  (feat_en_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .illegal_o  (illegal_o),
  .result_o   (result_o),
  .accept_w   (accept_w),
  .reject_w   (reject_w),
  .zero_fin_w (zero_fin_w),
  .finish_w   (finish_w),
  .b_zero_w   (b_zero_w)
);

// File: tb/clmul_seq_unit_test.sv
module clmul_seq_unit_test;
  localparam int HW = 64;
  localparam int OW = 2 * HW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          feat_en_i = 1'b1;
  logic [OW-1:0] dst_i = '0;
  logic [OW-1:0] src_i = '0;
  logic [7:0]    imm_i = '0;
  logic          busy_o, done_o, illegal_o;
  logic [OW-1:0] result_o;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  clmul_seq_unit #(.HALF_W(HW)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .feat_en_i(feat_en_i),
    .dst_i(dst_i), .src_i(src_i), .imm_i(imm_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  typedef struct packed {
    logic [OW-1:0] dst;
    logic [OW-1:0] src;
    logic [7:0]    imm;
    logic [OW-1:0] exp;
    logic [7:0]    lat;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    // R3 basic: (x+1)^2
    '{{64'h0, 64'h3}, {64'h0, 64'h3}, 8'h00, {64'h0, 64'h5}, 8'd3},
    // R1/R2 high halves, bit crossing into the high word
    '{{64'h8000_0000_0000_0000, 64'h1}, {64'h2, 64'h1}, 8'h11, {64'h1, 64'h0}, 8'd3},
    // R5 worst case, 64 steps
    '{{64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h8000_0000_0000_0000}, 8'h00,
      {64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000}, 8'd65},
    // R4 other control bits set, selectors low
    '{{64'h1234, 64'h5}, {64'h77, 64'h3}, 8'hEE, {64'h0, 64'hF}, 8'd3},
    // R1 first factor from high half only
    '{{64'h6, 64'hFF}, {64'h99, 64'h1}, 8'h01, {64'h0, 64'h6}, 8'd2},
    // R2 second factor from high half only
    '{{64'hAB, 64'h2}, {64'h4, 64'hFF}, 8'h10, {64'h0, 64'h8}, 8'd4},
    // R5 zero multiplier
    '{{OW{1'b1}}, {64'h5, 64'h0}, 8'h00, {OW{1'b0}}, 8'd1},
    // R5 zero multiplicand still runs all steps
    '{{64'h3, 64'h0}, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 8'h00, {OW{1'b0}}, 8'd65},
    // R4 all control bits set
    '{{64'h3, 64'h1}, {64'h3, 64'h1}, 8'hFF, {64'h0, 64'h5}, 8'd3}
  };

  function automatic logic [OW-1:0] ref_clmul(input logic [HW-1:0] a, input logic [HW-1:0] b);
    logic [OW-1:0] p = '0;
    for (int i = 0; i < HW; i++)
      for (int j = 0; j < HW; j++)
        if (a[i] && b[j]) p[i+j] = ~p[i+j];
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  logic [OW-1:0] r_res;
  int            r_lat;
  logic          r_ill;
  logic          r_busy_bad;

  task automatic run_op(input logic [OW-1:0] d, input logic [OW-1:0] s,
                        input logic [7:0] im, input logic fe);
    @(negedge clk);
    dst_i = d; src_i = s; imm_i = im; feat_en_i = fe; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    r_lat = 1;
    r_busy_bad = 1'b0;
    while (!done_o && r_lat < 300) begin
      if (!busy_o) r_busy_bad = 1'b1;
      @(negedge clk);
      r_lat++;
    end
    if (busy_o) r_busy_bad = 1'b1;
    r_res = result_o;
    r_ill = illegal_o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(!busy_o && !done_o && !illegal_o, "R9", {125'b0, busy_o, done_o, illegal_o}, '0);
    check(result_o == '0, "R9", result_o, '0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k].dst, VEC[k].src, VEC[k].imm, 1'b1);
      check(r_res == VEC[k].exp, "R3", r_res, VEC[k].exp);
      check(r_lat == int'(VEC[k].lat), "R5", OW'(r_lat), OW'(VEC[k].lat));
      check(!r_busy_bad && !r_ill, "R6", OW'({r_busy_bad, r_ill}), '0);
      @(negedge clk);
      check(!done_o, "R6", OW'(done_o), '0);
    end

    // R3 cross-check against the bench model on a dense pattern
    begin
      logic [OW-1:0] e;
      e = ref_clmul(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
      run_op({64'h0, 64'h0123_4567_89AB_CDEF}, {64'h0, 64'hFEDC_BA98_7654_3210}, 8'h00, 1'b1);
      check(r_res == e, "R3", r_res, e);
      check(r_lat == 65, "R5", OW'(r_lat), OW'(65));
    end

    // R8 feature disabled: illegal with done, result kept, never busy
    begin
      logic [OW-1:0] prev;
      prev = result_o;
      run_op({64'h0, 64'h3}, {64'h0, 64'h3}, 8'h00, 1'b0);
      check(r_ill == 1'b1, "R8", OW'(r_ill), OW'(1));
      check(r_lat == 1 && !busy_o, "R8", OW'(r_lat), OW'(1));
      check(r_res == prev, "R8", r_res, prev);
      feat_en_i = 1'b1;
    end

    // R7 second start while busy is dropped
    begin
      int lat;
      bit extra;
      @(negedge clk);
      dst_i = VEC[2].dst; src_i = VEC[2].src; imm_i = 8'h00; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat = 1;
      repeat (4) begin @(negedge clk); lat++; end
      dst_i = {64'h0, 64'h1}; src_i = {64'h0, 64'h1}; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      lat++;
      while (!done_o && lat < 300) begin @(negedge clk); lat++; end
      check(result_o == VEC[2].exp, "R7", result_o, VEC[2].exp);
      check(lat == 65, "R7", OW'(lat), OW'(65));
      extra = 1'b0;
      repeat (8) begin @(negedge clk); if (done_o) extra = 1'b1; end
      check(!extra, "R7", OW'(extra), '0);
    end

    // R9 reset in mid-run abandons the operation
    begin
      bit seen;
      @(negedge clk);
      dst_i = VEC[2].dst; src_i = VEC[2].src; imm_i = 8'h00; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check(!busy_o && !done_o && result_o == '0, "R9", result_o, '0);
      seen = 1'b0;
      repeat (80) begin @(negedge clk); if (done_o || busy_o) seen = 1'b1; end
      check(!seen, "R9", OW'(seen), '0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule